// File: doc/BRIEF.md
# In-order AXI4 read subordinate with out-of-order backend

This block is the read side of an AXI4 subordinate. Each burst accepted on the AR channel is put in a bounded queue and announced at once on a backend request port. The announcement carries the start address, the total byte length and an internal tag. The backend returns each burst's data in a single completion that carries the tag and the whole payload. Completions may come back in any order. The block still replays R beats strictly in the order the requests were accepted.

Narrow and unaligned bursts are placed on the byte lanes that the running address selects. Lanes that carry no data are driven to zero. Every output is a register, so a decision taken in one cycle reaches the manager in the next cycle. Only incrementing bursts are legal. The response code, wrapping and fixed bursts, and exclusive access are not handled.

Top module: `axi_rd_inorder_sub`

## Requirements
- R1: After reset, ar_ready is 1, and r_valid, r_last and be_req_valid are 0.
- R2: One cycle after each AR handshake, be_req_valid is 1 for one cycle. In that cycle be_req_addr is the burst address and be_req_bytes is 2^ar_size × (ar_len+1). Only ar_burst = 2'b01 (incrementing) is legal input, with ar_len+1 ≤ MAX_BEATS and 2^ar_size ≤ DATA_BYTES.
- R3: be_req_tag is {ar_id, seq}. seq is CNT_W bits wide and fills the low bits. It is 0 for the first request after reset and grows by one with each accepted request, wrapping modulo 2^CNT_W.
- R4: ar_ready is 0 exactly while DEPTH bursts are outstanding, meaning accepted and not yet retired. Retiring one burst raises it again in the next cycle.
- R5: A completion is matched to its queued burst by tag, and completions may arrive in any order. A burst produces no beat until its own completion has arrived and every earlier burst has been retired. When the next burst is already complete, it starts in the cycle right after its predecessor's last handshake.
- R6: r_id is the ar_id of the burst being replayed.
- R7: Bytes are counted from 0 within a burst, and payload byte k is be_cpl_data[8k+7:8k]. A beat starts on lane (address + bytes already sent) mod DATA_BYTES. It carries the fewest of three counts: DATA_BYTES minus that lane, 2^ar_size, and the bytes still to send. All other lanes are 0.
- R8: r_last is 1 on the beat where the bytes sent reach the burst length, and only on that beat.
- R9: While r_valid is 1 and r_ready is 0, r_valid, r_data, r_id and r_last hold their values.
- R10: Suppose a handshake with r_last set is not followed at once by another completed burst. Then r_valid, r_last, r_data and r_id are all 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_addr | input | ADDR_W | Burst start address |
| ar_id | input | ID_W | Transaction identifier |
| ar_len | input | 8 | Beats minus one |
| ar_size | input | 3 | Log2 of the bytes per beat |
| ar_burst | input | 2 | Burst type, must be 2'b01 |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_data | output | 8*DATA_BYTES | Read data beat |
| r_id | output | ID_W | Identifier of the replayed burst |
| r_last | output | 1 | Final beat of the burst |
| be_req_valid | output | 1 | Backend request strobe |
| be_req_addr | output | ADDR_W | Backend request address |
| be_req_bytes | output | 16 | Backend request byte length |
| be_req_tag | output | ID_W+CNT_W | Backend request tag |
| be_cpl_valid | input | 1 | Backend completion strobe |
| be_cpl_tag | input | ID_W+CNT_W | Tag of the completed burst |
| be_cpl_data | input | 8*DATA_BYTES*MAX_BEATS | Burst payload, byte 0 in the low bits |

## Verification
The hardest state to reach is a full queue whose oldest entry is still waiting while a further request sits stalled at the address channel. Reaching it needs DEPTH requests with no completion at all. The stimulus issues DEPTH single-beat bursts and answers none of them. It then holds one more request valid for several cycles and confirms that no backend request appears. Finally it completes only the oldest burst and checks that draining it lets the stalled request through. The remaining completions are then returned in reverse order to exercise reordering across the whole queue.

// File: rtl/rdsub_pkg.sv
package rdsub_pkg;

  localparam int BLEN_W = 16;
  typedef logic [BLEN_W-1:0] blen_t;

  localparam logic [1:0] BURST_INCR = 2'b01;

  // bytes moved per beat for a given size code
  function automatic blen_t step_bytes(input logic [2:0] size);
    return blen_t'(1) << size;
  endfunction

  // total bytes of a burst
  function automatic blen_t burst_bytes(input logic [2:0] size, input logic [7:0] len);
    return step_bytes(size) * (blen_t'(len) + blen_t'(1));
  endfunction

  // bytes a beat may carry: lanes left on the bus, step size, remaining bytes
  function automatic blen_t beat_take(input blen_t lane, input blen_t bus_bytes,
                                      input blen_t step, input blen_t remain);
    blen_t n;
    n = bus_bytes - lane;
    if (step < n) n = step;
    if (remain < n) n = remain;
    return n;
  endfunction

endpackage

// File: rtl/rdsub_ar_front.sv
module rdsub_ar_front
  import rdsub_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int CNT_W  = 8,
  localparam int TAG_W = ID_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [7:0]        ar_len,
  input  logic [2:0]        ar_size,
  input  logic              room_next,
  output logic              ar_ready,
  output logic              accept,
  output logic [TAG_W-1:0]  push_tag,
  output blen_t             push_bytes,
  output logic              be_req_valid,
  output logic [ADDR_W-1:0] be_req_addr,
  output blen_t             be_req_bytes,
  output logic [TAG_W-1:0]  be_req_tag
);

  logic [CNT_W-1:0] seq_q;
  logic             rdy_q;

  assign ar_ready   = rdy_q;
  assign accept     = ar_valid & rdy_q;
  assign push_tag   = {ar_id, seq_q};
  assign push_bytes = burst_bytes(ar_size, ar_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q        <= 1'b1;
      seq_q        <= '0;
      be_req_valid <= 1'b0;
      be_req_addr  <= '0;
      be_req_bytes <= '0;
      be_req_tag   <= '0;
    end else begin
      rdy_q        <= room_next;
      be_req_valid <= accept;
      if (accept) begin
        seq_q        <= seq_q + 1'b1;
        be_req_addr  <= ar_addr;
        be_req_bytes <= push_bytes;
        be_req_tag   <= push_tag;
      end
    end
  end

endmodule

// File: rtl/rdsub_queue.sv
module rdsub_queue
  import rdsub_pkg::*;
#(
  parameter int TAG_W = 12,
  parameter int ID_W  = 4,
  parameter int LO_W  = 2,
  parameter int DEPTH = 64,
  parameter int BUF_W = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [LO_W-1:0]  push_addr_lo,
  input  blen_t            push_bytes,
  input  logic [2:0]       push_size,
  input  logic             pop,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  input  logic [BUF_W-1:0] cpl_data,
  output logic             room_next,
  output logic             cpl_hit,
  output logic [CW-1:0]    used,
  output logic             vw_present,
  output logic             vw_done,
  output logic [ID_W-1:0]  vw_id,
  output logic [LO_W-1:0]  vw_addr_lo,
  output blen_t            vw_bytes,
  output logic [2:0]       vw_size,
  output logic [BUF_W-1:0] vw_data
);

  logic [TAG_W-1:0] tag_q   [DEPTH];
  logic [LO_W-1:0]  alo_q   [DEPTH];
  blen_t            bytes_q [DEPTH];
  logic [2:0]       size_q  [DEPTH];
  logic [BUF_W-1:0] data_q  [DEPTH];
  logic [DEPTH-1:0] valid_q, done_q, hit;
  logic [IDX_W-1:0] head_q, tail_q, vidx;
  logic [CW-1:0]    count_q, count_next;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_match
      assign hit[g] = cpl_valid && valid_q[g] && !done_q[g] && (tag_q[g] == cpl_tag);
    end
  endgenerate

  assign cpl_hit    = |hit;
  assign count_next = count_q + CW'(push) - CW'(pop);
  assign room_next  = (count_next < CW'(DEPTH));
  assign used       = count_q;

  // view of the entry that will be at the head once this cycle's retire is done
  assign vidx       = pop ? wrap_inc(head_q) : head_q;
  assign vw_present = valid_q[vidx];
  assign vw_done    = done_q[vidx];
  assign vw_id      = tag_q[vidx][TAG_W-1 -: ID_W];
  assign vw_addr_lo = alo_q[vidx];
  assign vw_bytes   = bytes_q[vidx];
  assign vw_size    = size_q[vidx];
  assign vw_data    = data_q[vidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      valid_q <= '0;
      done_q  <= '0;
    end else begin
      if (push) begin
        valid_q[tail_q] <= 1'b1;
        done_q[tail_q]  <= 1'b0;
        tail_q          <= wrap_inc(tail_q);
      end
      if (pop) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= wrap_inc(head_q);
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (hit[i]) done_q[i] <= 1'b1;
      end
      count_q <= count_next;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      tag_q[tail_q]   <= push_tag;
      alo_q[tail_q]   <= push_addr_lo;
      bytes_q[tail_q] <= push_bytes;
      size_q[tail_q]  <= push_size;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) data_q[i] <= cpl_data;
    end
  end

endmodule

// File: rtl/rdsub_beat_gen.sv
module rdsub_beat_gen
  import rdsub_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int DATA_BYTES = 4,
  parameter int BUF_W      = 128,
  localparam int LO_W      = $clog2(DATA_BYTES),
  localparam int DATA_W    = 8 * DATA_BYTES,
  localparam int BUF_BYTES = BUF_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              r_ready,
  input  logic              vw_present,
  input  logic              vw_done,
  input  logic [ID_W-1:0]   vw_id,
  input  logic [LO_W-1:0]   vw_addr_lo,
  input  blen_t             vw_bytes,
  input  logic [2:0]        vw_size,
  input  logic [BUF_W-1:0]  vw_data,
  output logic              r_valid,
  output logic [DATA_W-1:0] r_data,
  output logic [ID_W-1:0]   r_id,
  output logic              r_last,
  output logic              pop,
  output logic              start
);

  logic              r_valid_q, r_last_q, adv;
  logic [DATA_W-1:0] r_data_q, beat;
  logic [ID_W-1:0]   r_id_q;
  blen_t             off_q, off_base, lane, take, sent_next;
  logic              last_next;

  function automatic blen_t lane_of(input logic [LO_W-1:0] alo, input blen_t off);
    return blen_t'((int'(alo) + int'(off)) % DATA_BYTES);
  endfunction

  function automatic logic [DATA_W-1:0] place(input logic [BUF_W-1:0] buf_i,
                                              input blen_t off, input blen_t ln,
                                              input blen_t n);
    logic [DATA_W-1:0] d;
    int src;
    d = '0;
    for (int l = 0; l < DATA_BYTES; l++) begin
      if (l >= int'(ln) && l < int'(ln) + int'(n)) begin
        src = int'(off) + l - int'(ln);
        if (src < BUF_BYTES) d[l*8 +: 8] = buf_i[src*8 +: 8];
      end
    end
    return d;
  endfunction

  assign pop       = r_valid_q & r_ready & r_last_q;
  assign adv       = r_valid_q & r_ready & ~r_last_q;
  assign start     = (~r_valid_q | pop) & vw_present & vw_done;
  assign off_base  = start ? '0 : off_q;
  assign lane      = lane_of(vw_addr_lo, off_base);
  assign take      = beat_take(lane, blen_t'(DATA_BYTES), step_bytes(vw_size), vw_bytes - off_base);
  assign beat      = place(vw_data, off_base, lane, take);
  assign sent_next = off_base + take;
  assign last_next = (sent_next == vw_bytes);

  assign r_valid = r_valid_q;
  assign r_data  = r_data_q;
  assign r_id    = r_id_q;
  assign r_last  = r_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid_q <= 1'b0;
      r_last_q  <= 1'b0;
      r_data_q  <= '0;
      r_id_q    <= '0;
      off_q     <= '0;
    end else if (start) begin
      r_valid_q <= 1'b1;
      r_id_q    <= vw_id;
      r_data_q  <= beat;
      r_last_q  <= last_next;
      off_q     <= sent_next;
    end else if (pop) begin
      r_valid_q <= 1'b0;
      r_last_q  <= 1'b0;
      r_data_q  <= '0;
      r_id_q    <= '0;
      off_q     <= '0;
    end else if (adv) begin
      r_data_q  <= beat;
      r_last_q  <= last_next;
      off_q     <= sent_next;
    end
  end

endmodule

// File: rtl/axi_rd_inorder_sub.sv
module axi_rd_inorder_sub
  import rdsub_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int CNT_W      = 8,
  parameter int DATA_BYTES = 4,
  parameter int MAX_BEATS  = 4,
  parameter int DEPTH      = 64,
  localparam int TAG_W     = ID_W + CNT_W,
  localparam int DATA_W    = 8 * DATA_BYTES,
  localparam int BUF_W     = 8 * DATA_BYTES * MAX_BEATS,
  localparam int LO_W      = $clog2(DATA_BYTES),
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [7:0]        ar_len,
  input  logic [2:0]        ar_size,
  input  logic [1:0]        ar_burst,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [DATA_W-1:0] r_data,
  output logic [ID_W-1:0]   r_id,
  output logic              r_last,
  output logic              be_req_valid,
  output logic [ADDR_W-1:0] be_req_addr,
  output logic [15:0]       be_req_bytes,
  output logic [TAG_W-1:0]  be_req_tag,
  input  logic              be_cpl_valid,
  input  logic [TAG_W-1:0]  be_cpl_tag,
  input  logic [BUF_W-1:0]  be_cpl_data
);

  // named internal events, also observed by the bound checker
  logic             accept_evt, pop_evt, start_evt, cpl_hit, room_next;
  logic [CW-1:0]    used_cnt;
  logic [TAG_W-1:0] push_tag;
  blen_t            push_bytes;
  logic             vw_present, vw_done;
  logic [ID_W-1:0]  vw_id;
  logic [LO_W-1:0]  vw_addr_lo;
  blen_t            vw_bytes;
  logic [2:0]       vw_size;
  logic [BUF_W-1:0] vw_data;

  rdsub_ar_front #(.ADDR_W(ADDR_W), .ID_W(ID_W), .CNT_W(CNT_W)) u_front (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_addr(ar_addr), .ar_id(ar_id),
    .ar_len(ar_len), .ar_size(ar_size),
    .room_next(room_next), .ar_ready(ar_ready), .accept(accept_evt),
    .push_tag(push_tag), .push_bytes(push_bytes),
    .be_req_valid(be_req_valid), .be_req_addr(be_req_addr),
    .be_req_bytes(be_req_bytes), .be_req_tag(be_req_tag)
  );

  rdsub_queue #(.TAG_W(TAG_W), .ID_W(ID_W), .LO_W(LO_W), .DEPTH(DEPTH), .BUF_W(BUF_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(accept_evt), .push_tag(push_tag), .push_addr_lo(ar_addr[LO_W-1:0]),
    .push_bytes(push_bytes), .push_size(ar_size),
    .pop(pop_evt),
    .cpl_valid(be_cpl_valid), .cpl_tag(be_cpl_tag), .cpl_data(be_cpl_data),
    .room_next(room_next), .cpl_hit(cpl_hit), .used(used_cnt),
    .vw_present(vw_present), .vw_done(vw_done), .vw_id(vw_id),
    .vw_addr_lo(vw_addr_lo), .vw_bytes(vw_bytes), .vw_size(vw_size), .vw_data(vw_data)
  );

  rdsub_beat_gen #(.ID_W(ID_W), .DATA_BYTES(DATA_BYTES), .BUF_W(BUF_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .r_ready(r_ready),
    .vw_present(vw_present), .vw_done(vw_done), .vw_id(vw_id),
    .vw_addr_lo(vw_addr_lo), .vw_bytes(vw_bytes), .vw_size(vw_size), .vw_data(vw_data),
    .r_valid(r_valid), .r_data(r_data), .r_id(r_id), .r_last(r_last),
    .pop(pop_evt), .start(start_evt)
  );

endmodule

// File: rtl/axi_rd_inorder_sub_chk.sv
module axi_rd_inorder_sub_chk #(
  parameter int ID_W       = 4,
  parameter int DATA_BYTES = 4,
  parameter int MAX_BEATS  = 4,
  parameter int DEPTH      = 64,
  localparam int DATA_W    = 8 * DATA_BYTES,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [7:0]        ar_len,
  input logic [2:0]        ar_size,
  input logic [1:0]        ar_burst,
  input logic              be_req_valid,
  input logic              r_valid,
  input logic              r_ready,
  input logic [DATA_W-1:0] r_data,
  input logic [ID_W-1:0]   r_id,
  input logic              r_last,
  input logic              be_cpl_valid,
  input logic              cpl_hit,
  input logic [CW-1:0]     used_cnt,
  input logic              start_evt,
  input logic              pop_evt
);

  // R4
  room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_ready == (used_cnt < CW'(DEPTH)));

  // R2
  req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |=> be_req_valid);

  // R2
  legal_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |-> (ar_burst == 2'b01 && int'(ar_len) < MAX_BEATS
                                && (32'd1 << ar_size) <= DATA_BYTES));

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_id) && $stable(r_last)));

  // R10
  retire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !start_evt) |=> (!r_valid && !r_last && r_data == '0 && r_id == '0));

  // R5
  cpl_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_cpl_valid |-> cpl_hit);

  // R5
  start_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> r_valid);

endmodule

bind axi_rd_inorder_sub axi_rd_inorder_sub_chk #(
  .ID_W(ID_W), .DATA_BYTES(DATA_BYTES), .MAX_BEATS(MAX_BEATS), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
  .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
  .be_req_valid(be_req_valid), .r_valid(r_valid), .r_ready(r_ready),
  .r_data(r_data), .r_id(r_id), .r_last(r_last),
  .be_cpl_valid(be_cpl_valid), .cpl_hit(cpl_hit), .used_cnt(used_cnt),
  .start_evt(start_evt), .pop_evt(pop_evt)
);

// File: tb/axi_rd_inorder_sub_tb.sv
module axi_rd_inorder_sub_tb;

  localparam int CLK_P = 10;
  localparam int DB    = 4;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ar_valid = 1'b0;
  logic        ar_ready;
  logic [31:0] ar_addr = '0;
  logic [3:0]  ar_id = '0;
  logic [7:0]  ar_len = '0;
  logic [2:0]  ar_size = '0;
  logic [1:0]  ar_burst = 2'b01;
  logic        r_valid;
  logic        r_ready = 1'b0;
  logic [31:0] r_data;
  logic [3:0]  r_id;
  logic        r_last;
  logic        be_req_valid;
  logic [31:0] be_req_addr;
  logic [15:0] be_req_bytes;
  logic [11:0] be_req_tag;
  logic        be_cpl_valid = 1'b0;
  logic [11:0] be_cpl_tag = '0;
  logic [127:0] be_cpl_data = '0;

  axi_rd_inorder_sub u_dut (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_id(ar_id),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_id(r_id), .r_last(r_last),
    .be_req_valid(be_req_valid), .be_req_addr(be_req_addr),
    .be_req_bytes(be_req_bytes), .be_req_tag(be_req_tag),
    .be_cpl_valid(be_cpl_valid), .be_cpl_tag(be_cpl_tag), .be_cpl_data(be_cpl_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int n_iss = 0;
  int n_drained = 0;
  int          exp_addr [256];
  logic [3:0]  exp_id   [256];
  int          exp_len  [256];
  int          exp_size [256];
  logic [11:0] tag_log  [256];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] pbyte(input int idx, input int k);
    return 8'((idx * 17 + k * 5 + 3) & 255);
  endfunction

  // issue one read burst and check the backend request it produces (R2, R3)
  task automatic send_ar(input int a, input logic [3:0] id, input int len, input int size);
    @(negedge clk);
    ar_valid = 1'b1; ar_addr = 32'(a); ar_id = id; ar_len = 8'(len); ar_size = 3'(size);
    while (!ar_ready) @(negedge clk);
    @(negedge clk);
    ar_valid = 1'b0;
    chk(be_req_valid == 1'b1, "R2 request strobe", be_req_valid, 1);
    chk(be_req_addr == 32'(a), "R2 request address", be_req_addr, a);
    chk(int'(be_req_bytes) == (1 << size) * (len + 1), "R2 request bytes",
        be_req_bytes, (1 << size) * (len + 1));
    chk(be_req_tag == {id, 8'(n_iss)}, "R3 request tag", be_req_tag, {id, 8'(n_iss)});
    exp_addr[n_iss] = a; exp_id[n_iss] = id; exp_len[n_iss] = len; exp_size[n_iss] = size;
    tag_log[n_iss] = be_req_tag;
    n_iss++;
  endtask

  task automatic complete(input int idx);
    @(negedge clk);
    be_cpl_valid = 1'b1;
    be_cpl_tag = tag_log[idx];
    for (int k = 0; k < 16; k++) be_cpl_data[k*8 +: 8] = pbyte(idx, k);
    @(negedge clk);
    be_cpl_valid = 1'b0;
  endtask

  // consume the oldest undrained burst, comparing each beat to a byte walk
  task automatic drain(input bit stall, input bit want_clear);
    int idx, step, total, off, cnt, t;
    logic [31:0] ed, sd;
    bit el, more, sl;
    idx = n_drained;
    step = 1 << exp_size[idx];
    total = step * (exp_len[idx] + 1);
    off = 0;
    while (off < total) begin
      ed = '0; cnt = 0; more = 1'b1;
      while (more) begin
        ed[((exp_addr[idx] + off) % DB) * 8 +: 8] = pbyte(idx, off);
        off++; cnt++;
        more = (cnt < step) && (off < total) && (((exp_addr[idx] + off) % DB) != 0);
      end
      el = (off == total);
      t = 0;
      while (!r_valid && t < 400) begin @(negedge clk); t++; end
      chk(r_valid == 1'b1, "R5 beat offered", r_valid, 1);
      chk(r_data == ed, "R7 lane data", r_data, ed);
      chk(r_id == exp_id[idx], "R6 beat id", r_id, exp_id[idx]);
      chk(r_last == el, "R8 last flag", r_last, el);
      if (stall) begin
        sd = r_data; sl = r_last;
        @(negedge clk); @(negedge clk);
        chk(r_valid && r_data == sd && r_last == sl, "R9 held beat", r_data, sd);
      end
      r_ready = 1'b1;
      @(negedge clk);
      r_ready = 1'b0;
    end
    n_drained++;
    if (want_clear)
      chk(!r_valid && !r_last && r_data == '0 && r_id == '0, "R10 cleared after last",
          {r_valid, r_last, r_id, r_data}, 0);
  endtask

  task automatic t_reset();
    chk(ar_ready == 1'b1, "R1 ar_ready after reset", ar_ready, 1);
    chk(r_valid == 1'b0 && r_last == 1'b0, "R1 r_valid/r_last after reset", {r_valid, r_last}, 0);
    chk(be_req_valid == 1'b0, "R1 request idle after reset", be_req_valid, 0);
  endtask

  task automatic t_aligned();
    send_ar(32'h100, 4'd5, 3, 2);
    complete(n_iss - 1);
    drain(1'b1, 1'b1);
  endtask

  task automatic t_narrow();
    send_ar(32'h201, 4'd3, 3, 0);
    complete(n_iss - 1);
    drain(1'b0, 1'b1);
    send_ar(32'h403, 4'd7, 2, 1);
    complete(n_iss - 1);
    drain(1'b1, 1'b1);
  endtask

  task automatic t_unaligned();
    send_ar(32'h302, 4'd9, 1, 2);
    complete(n_iss - 1);
    drain(1'b0, 1'b1);
  endtask

  task automatic t_reorder();
    int b, quiet;
    b = n_iss;
    send_ar(32'h500, 4'd1, 1, 2);
    send_ar(32'h601, 4'd2, 2, 0);
    send_ar(32'h702, 4'd3, 3, 1);
    complete(b + 2);
    complete(b + 1);
    quiet = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (r_valid) quiet = 0;
    end
    chk(quiet == 1, "R5 no beat before head completes", quiet, 1);
    complete(b);
    drain(1'b0, 1'b0);
    chk(r_valid == 1'b1 && r_id == 4'd2, "R5 next burst follows at once", r_id, 2);
    drain(1'b0, 1'b0);
    drain(1'b1, 1'b1);
  endtask

  task automatic t_full();
    int b, quiet;
    b = n_iss;
    for (int i = 0; i < DEPTH; i++) send_ar(32'h1000 + i * 4, 4'(i % 16), 0, 2);
    chk(ar_ready == 1'b0, "R4 ar_ready low when full", ar_ready, 0);
    @(negedge clk);
    ar_valid = 1'b1; ar_addr = 32'h2000; ar_id = 4'hE; ar_len = 8'd1; ar_size = 3'd2;
    quiet = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (be_req_valid || ar_ready) quiet = 0;
    end
    chk(quiet == 1, "R4 extra request stalled", quiet, 1);
    complete(b);
    drain(1'b0, 1'b1);
    chk(ar_ready == 1'b1, "R4 ar_ready back after retire", ar_ready, 1);
    @(negedge clk);
    ar_valid = 1'b0;
    chk(be_req_valid == 1'b1 && be_req_tag == {4'hE, 8'(n_iss)}, "R3 stalled request tag",
        be_req_tag, {4'hE, 8'(n_iss)});
    exp_addr[n_iss] = 32'h2000; exp_id[n_iss] = 4'hE; exp_len[n_iss] = 1; exp_size[n_iss] = 2;
    tag_log[n_iss] = be_req_tag;
    n_iss++;
    for (int i = n_iss - 1; i > b; i--) complete(i);
    for (int i = b + 1; i < n_iss; i++) drain(i[0], i == n_iss - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_narrow();
    t_unaligned();
    t_reorder();
    t_full();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule